// File: doc/BRIEF.md
# LCD Row Data Output Latch

This block holds one row of display data on its way from a display RAM read port to the segment driver outputs. When the line strobe is high at a rising clock edge, the block copies the whole row into an internal register. It then drives the row to the segment bus until the next strobe.

Three mode inputs shape what reaches the segment bus:
- **Blank** switches every segment off.
- **Force-on** lights every segment.
- **Invert** flips every bit.

These modes act only on the path from the register to the outputs. The stored row is never rewritten, so the display can change state without any access to the RAM. A mode change shows on the outputs in the same cycle. It does not wait for the next line strobe.

Top module: `lcd_row_latch`

## Requirements
- R1: While `rst_n` is low, and after it is released, the stored row is all zeros until the first strobe. With `disp_en`=1, `all_on`=0 and `invert`=0 this shows as `seg_out`=0.
- R2: When `line_load` is 1 at a rising clock edge, the stored row takes the value of `row_in`. Just after that edge, `seg_out` shows the new row, passed through the current mode inputs.
- R3: When `line_load` is 0 at a rising edge, the stored row keeps its value and `row_in` has no effect on `seg_out`.
- R4: With `disp_en`=1, `all_on`=0 and `invert`=0, `seg_out` equals the stored row bit for bit. Bit i drives segment column i.
- R5: With `disp_en`=1, `all_on`=0 and `invert`=1, every bit of `seg_out` is the inverse of the stored bit.
- R6: With `disp_en`=0, `seg_out` is all zeros, whatever the values of `all_on` and `invert`.
- R7: With `disp_en`=1 and `all_on`=1, `seg_out` is all ones, whatever the value of `invert`.
- R8: A change on `disp_en`, `all_on` or `invert` reaches `seg_out` without a clock edge.
- R9: Blanking, forcing on or inverting never changes the stored row. After a return to normal mode, `seg_out` shows the last loaded row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_load | input | 1 | Line strobe; the row is captured at the rising edge when this is 1 |
| row_in | input | COLS (132) | Row read from the display RAM |
| disp_en | input | 1 | Display on (1) or blank (0) |
| all_on | input | 1 | Force every segment on |
| invert | input | 1 | Reverse the displayed data |
| seg_out | output | COLS (132) | Segment driver data |

## Verification
The hardest case to reach from the ports is proving that the modes left the stored row alone (R9). The row register is never visible while blank or force-on is active.

To reach it, the bench loads a known row and then cycles through each modifier over several clocks while `row_in` carries a different pattern and the strobe stays low. It then returns to normal mode and compares the outputs with the row loaded earlier.

Mode changes are also checked between clock edges. This shows that the outputs follow the mode inputs without waiting for a clock.

// File: rtl/lcd_row_latch.sv
module lcd_row_latch #(
  parameter int COLS = 132
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_load,
  input  logic [COLS-1:0] row_in,
  input  logic            disp_en,
  input  logic            all_on,
  input  logic            invert,
  output logic [COLS-1:0] seg_out
);

  logic [COLS-1:0] lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         lat <= '0;
    else if (line_load) lat <= row_in;

  assign seg_out = !disp_en ? '0 :
                   all_on   ? '1 :
                   invert   ? ~lat : lat;

endmodule

module lcd_row_latch_chk #(
  parameter int COLS = 132
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_load,
  input logic [COLS-1:0] row_in,
  input logic            disp_en,
  input logic            all_on,
  input logic            invert,
  input logic [COLS-1:0] lat,
  input logic [COLS-1:0] seg_out
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> lat == '0);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_load |=> lat == $past(row_in));

  // R3
  hold_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_load |=> $stable(lat));

  // R4
  normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !all_on && !invert) |-> seg_out == lat);

  // R5
  reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !all_on && invert) |-> seg_out == ~lat);

  // R6
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> seg_out == '0);

  // R7
  force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && all_on) |-> &seg_out);

endmodule

bind lcd_row_latch lcd_row_latch_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_load(line_load), .row_in(row_in),
  .disp_en(disp_en), .all_on(all_on), .invert(invert),
  .lat(lat), .seg_out(seg_out)
);

// File: tb/lcd_row_latch_bench.sv
module lcd_row_latch_bench;
  localparam int COLS = 132;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            line_load = 1'b0;
  logic [COLS-1:0] row_in = '0;
  logic            disp_en = 1'b0;
  logic            all_on = 1'b0;
  logic            invert = 1'b0;
  logic [COLS-1:0] seg_out;

  int compared = 0;
  int mismatched = 0;
  logic [COLS-1:0] mlat = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  lcd_row_latch #(.COLS(COLS)) u_lcd_row_latch (
    .clk(clk), .rst_n(rst_n), .line_load(line_load), .row_in(row_in),
    .disp_en(disp_en), .all_on(all_on), .invert(invert), .seg_out(seg_out)
  );

  function automatic logic [COLS-1:0] pat(input logic [7:0] s);
    logic [135:0] w;
    w = {17{s}};
    pat = w[COLS-1:0] ^ (COLS'(s) << 64);
  endfunction

  function automatic logic [COLS-1:0] model(input logic [COLS-1:0] l,
                                             input logic en, input logic al, input logic iv);
    if (!en)     model = '0;
    else if (al) model = '1;
    else if (iv) model = ~l;
    else         model = l;
  endfunction

  task automatic check(input string req, input logic [COLS-1:0] exp);
    compared++;
    if (seg_out !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, seg_out, exp);
    end
  endtask

  // {seed[7:0], load, disp_en, all_on, invert}
  localparam logic [11:0] VEC [10] = '{
    {8'hA5, 4'b1100}, {8'h3C, 4'b0100}, {8'h0F, 4'b1101},
    {8'hF0, 4'b0110}, {8'h81, 4'b1111}, {8'h7E, 4'b1000},
    {8'h55, 4'b0010}, {8'hC3, 4'b1100}, {8'h18, 4'b0101},
    {8'hFF, 4'b1100}
  };

  initial begin
    #5;
    // R1: reset held, display on, normal -> zeros
    disp_en = 1'b1;
    #10 check("R1", '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1", '0);

    foreach (VEC[i]) begin
      @(negedge clk);
      row_in    = pat(VEC[i][11:4]);
      line_load = VEC[i][3];
      disp_en   = VEC[i][2];
      all_on    = VEC[i][1];
      invert    = VEC[i][0];
      @(posedge clk);
      if (VEC[i][3]) mlat = pat(VEC[i][11:4]);
      #5;
      check(VEC[i][3] ? "R2" : "R3", model(mlat, disp_en, all_on, invert));
    end

    // R2/R4: load a known row in normal mode
    @(negedge clk);
    row_in = pat(8'h96); line_load = 1'b1; disp_en = 1'b1; all_on = 1'b0; invert = 1'b0;
    @(posedge clk); mlat = pat(8'h96); #5;
    check("R4", mlat);

    // R3: strobe low, different data ignored
    @(negedge clk); line_load = 1'b0; row_in = pat(8'h69);
    @(posedge clk); #5; check("R3", mlat);

    // R8: mode changes without a clock edge
    @(negedge clk);
    invert = 1'b1; #1 check("R8", ~mlat);
    all_on = 1'b1; #1 check("R8", '1);
    disp_en = 1'b0; #1 check("R8", '0);

    // R6: blank overrides force-on and invert
    repeat (2) @(posedge clk);
    #5 check("R6", '0);
    // R7: force-on overrides invert
    disp_en = 1'b1; #1 check("R7", '1);
    repeat (2) @(posedge clk);
    // R5
    #5 all_on = 1'b0; #1 check("R5", ~mlat);
    // R9: back to normal shows the earlier row
    invert = 1'b0; #1 check("R9", mlat);

    // R1: reset in mid-run clears the row
    @(negedge clk); rst_n = 1'b0; #1 check("R1", '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1", '0);

    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule